// File: doc/BRIEF.md
# Locked NIC Control Register File

This block is the byte-wide control register bank of a network controller. A host reaches it through a plain port: an 8-bit address, 8-bit write data, a write strobe, a read strobe and an 8-bit read data bus. Read data is registered. It appears on `host_rdata` one clock after the cycle in which `host_rd` is high. Writes take effect at the clock edge of the strobe cycle.

The bank holds a six-byte station address, a small set of configuration bytes, a command register and a key register. The station address and the configuration bytes are protected. They change only while the key register's two mode bits are both set.

Writing the reset bit of the command register starts a soft reset. The reset restores every register to its default value at once. The block then stays busy for a parameterised number of cycles. While busy it ignores every write and answers every read with the reset bit set. When the count expires, the reset bit clears by itself.

The port carries single register accesses, not a data stream. It has no back-pressure: every strobe is taken in the cycle it is given, and a write dropped by the lock or by a reset leaves no trace. The block has no clock enable, and a write and a read may be issued in the same cycle.

Top module: `nic_ctrl_regs`

## Requirements
- R1: Offsets 0x00..0x05 hold the station address, one byte per offset. After a hardware reset, offset i reads `MAC_DEFAULT[8*i+7:8*i]`. `host_rdata` shows the addressed byte on the clock edge that samples `host_rd`.
- R2: A write to offset 0x37 with data bit 4 set (mask 0x10) starts a soft reset. At that same clock edge every register returns to its hardware-reset default.
- R3: From the starting edge, offset 0x37 reads 0x10 for exactly `RST_CYCLES` clock cycles. After that it reads 0x00.
- R4: The key register is at offset 0x50, and its mode bits are data bits [7:6]. Mode 2'b11 unlocks the protected registers. The key register reads back its mode bits in bits [7:6], with bits [5:0] reading 0.
- R5: The protected registers are the station address (0x00..0x05) and the configuration bytes (0x51 up to 0x51+`NUM_CFG`-1). While the block is locked, a write to a protected register is dropped and the register keeps its value.
- R6: Writing any mode other than 2'b11 to the key register locks the block again.
- R7: While a soft reset is in progress, every write is ignored, including writes to the key register and a repeated reset. A read of any offset returns 0x10.
- R8: After a hardware reset or a soft reset, the key register reads 0x00 (locked). Each configuration byte reads `CFG_DEFAULT`.
- R9: A write to 0x37 with bit 4 clear has no effect, and 0x37 reads 0x00 when no reset is in progress. Offsets that map to no register read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data, valid the cycle after the strobe |

## Verification
The bench builds the block with `RST_CYCLES` = 10 so that the busy window can be probed cycle by cycle, including its last busy cycle and the first free one. `NUM_CFG` is set to 3. `CFG_DEFAULT` is set to 0x5A, so that a restored default is told apart from zero and from written data. `MAC_DEFAULT` has a distinct value in every byte, which exposes any swap in byte order. With these values, a full reset and the checks around it take a few dozen cycles.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

  localparam int BYTE_W    = 8;
  localparam int STA_BYTES = 6;

  localparam logic [7:0] OFS_CMD  = 8'h37;
  localparam logic [7:0] OFS_KEY  = 8'h50;
  localparam logic [7:0] OFS_CFG0 = 8'h51;

  localparam int         RST_BIT     = 4;
  localparam logic [7:0] RST_STATUS  = 8'h10;
  localparam logic [1:0] MODE_UNLOCK = 2'b11;
  localparam logic [1:0] MODE_LOCKED = 2'b00;

  typedef struct packed {
    logic       hit_sta;
    logic [2:0] sta_idx;
    logic       hit_cmd;
    logic       hit_key;
    logic       hit_cfg;
    logic [7:0] cfg_off;
  } reg_sel_t;

endpackage

// File: rtl/nic_addr_decode.sv
module nic_addr_decode
  import nic_regs_pkg::*;
#(
  parameter int NUM_CFG = 4
) (
  input  logic [7:0] addr,
  output reg_sel_t   sel
);

  logic [7:0] off;

  always_comb begin
    off         = addr - OFS_CFG0;
    sel.hit_sta = (addr < 8'(STA_BYTES));
    sel.sta_idx = addr[2:0];
    sel.hit_cmd = (addr == OFS_CMD);
    sel.hit_key = (addr == OFS_KEY);
    sel.hit_cfg = (addr >= OFS_CFG0) && (off < 8'(NUM_CFG));
    sel.cfg_off = off;
  end

endmodule

// File: rtl/nic_key_gate.sv
module nic_key_gate
  import nic_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic [1:0] mode_in,
  output logic [1:0] mode_q,
  output logic       unlocked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_LOCKED;
    else if (clear) mode_q <= MODE_LOCKED;
    else if (load)  mode_q <= mode_in;
  end

  assign unlocked = (mode_q == MODE_UNLOCK);

endmodule

// File: rtl/nic_reset_seq.sv
module nic_reset_seq #(
  parameter int RST_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= CNT_W'(RST_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_regs_pkg::*;
#(
  parameter int          RST_CYCLES  = 64,
  parameter int          NUM_CFG     = 4,
  parameter logic [47:0] MAC_DEFAULT = 48'h9A78_5634_1200,
  parameter logic [7:0]  CFG_DEFAULT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_wr,
  input  logic       host_rd,
  output logic [7:0] host_rdata
);

  reg_sel_t sel;
  logic     busy;
  logic     unlocked;
  logic [1:0] key_mode;
  logic     accept;
  logic     rst_start;
  logic     prot_we;

  logic [STA_BYTES-1:0][BYTE_W-1:0] sta_q;
  logic [NUM_CFG-1:0][BYTE_W-1:0]   cfg_q;
  logic [BYTE_W-1:0]                rd_mux;

  nic_addr_decode #(.NUM_CFG(NUM_CFG)) u_dec (
    .addr (host_addr),
    .sel  (sel)
  );

  assign accept    = host_wr && !busy;
  assign rst_start = accept && sel.hit_cmd && host_wdata[RST_BIT];
  assign prot_we   = accept && unlocked;

  nic_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rst_start),
    .busy  (busy)
  );

  nic_key_gate u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (rst_start),
    .load     (accept && sel.hit_key),
    .mode_in  (host_wdata[7:6]),
    .mode_q   (key_mode),
    .unlocked (unlocked)
  );

  for (genvar i = 0; i < STA_BYTES; i++) begin : g_sta
    localparam logic [7:0] DFLT = MAC_DEFAULT[8*i +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sta_q[i] <= DFLT;
      else if (rst_start) sta_q[i] <= DFLT;
      else if (prot_we && sel.hit_sta && sel.sta_idx == 3'(i))
        sta_q[i] <= host_wdata;
    end
  end

  for (genvar j = 0; j < NUM_CFG; j++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[j] <= CFG_DEFAULT;
      else if (rst_start) cfg_q[j] <= CFG_DEFAULT;
      else if (prot_we && sel.hit_cfg && sel.cfg_off == 8'(j))
        cfg_q[j] <= host_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < STA_BYTES; i++)
      if (sel.hit_sta && sel.sta_idx == 3'(i)) rd_mux = sta_q[i];
    for (int j = 0; j < NUM_CFG; j++)
      if (sel.hit_cfg && sel.cfg_off == 8'(j)) rd_mux = cfg_q[j];
    if (sel.hit_key) rd_mux = {key_mode, 6'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= busy ? RST_STATUS : rd_mux;
  end

endmodule

// File: rtl/nic_ctrl_regs_chk.sv
module nic_ctrl_regs_chk #(
  parameter int         RST_CYCLES  = 64,
  parameter int         NUM_CFG     = 4,
  parameter logic [7:0] CFG_DEFAULT = 8'h00
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [7:0]              host_addr,
  input logic [7:0]              host_wdata,
  input logic                    host_wr,
  input logic                    host_rd,
  input logic [7:0]              host_rdata,
  input logic                    busy,
  input logic                    unlocked,
  input logic [1:0]              key_mode,
  input logic [NUM_CFG-1:0][7:0] cfg_q,
  input logic [5:0][7:0]         sta_q
);

  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_wr && host_addr == 8'h37 && host_wdata[4]) |=> busy);

  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == RST_CYCLES);

  a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < RST_CYCLES);

  a_r5_locked_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !unlocked && host_wr && host_addr != 8'h37)
      |=> ($stable(cfg_q) && $stable(sta_q)));

  a_r6_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_wr && host_addr == 8'h50 && host_wdata[7:6] != 2'b11)
      |=> !unlocked);

  a_r7_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr)
      |=> ($stable(key_mode) && $stable(cfg_q) && $stable(sta_q)));

  a_r7_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_rd) |=> host_rdata == 8'h10);

  a_r8_soft_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (key_mode == 2'b00 && cfg_q == {NUM_CFG{CFG_DEFAULT}}));

endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk #(
  .RST_CYCLES  (RST_CYCLES),
  .NUM_CFG     (NUM_CFG),
  .CFG_DEFAULT (CFG_DEFAULT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .busy       (busy),
  .unlocked   (unlocked),
  .key_mode   (key_mode),
  .cfg_q      (cfg_q),
  .sta_q      (sta_q)
);

// File: tb/test_nic_ctrl_regs.sv
module test_nic_ctrl_regs;

  localparam int          CLK_PERIOD = 10;
  localparam int          RST_CYC    = 10;
  localparam int          NCFG       = 3;
  localparam logic [47:0] MAC_DFLT   = 48'hA1B2_C3D4_E5F6;
  localparam logic [7:0]  CFG_DFLT   = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] host_addr;
  logic [7:0] host_wdata;
  logic       host_wr;
  logic       host_rd;
  logic [7:0] host_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       sb_fire = 1'b0;

  nic_ctrl_regs #(
    .RST_CYCLES  (RST_CYC),
    .NUM_CFG     (NCFG),
    .MAC_DEFAULT (MAC_DFLT),
    .CFG_DEFAULT (CFG_DFLT)
  ) i_nic_ctrl_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: a read strobe seen at a rising edge is compared at the next falling edge
  always @(posedge clk) sb_fire <= host_rd;

  always @(negedge clk) begin
    if (sb_fire === 1'b1) begin
      logic [7:0] e;
      string      t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read data %h with no expected item", host_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", t, host_rdata, e);
        end
      end
    end
  end

  // driver tasks: called at a falling edge, each takes one cycle
  task automatic wr8(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1; host_rd = 1'b0;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd8(input logic [7:0] a, input logic [7:0] e, input string t);
    host_addr = a; host_rd = 1'b1; host_wr = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R8: hardware reset state
    for (int i = 0; i < 6; i++) rd8(8'(i), MAC_DFLT[8*i +: 8], "R1");
    rd8(8'h50, 8'h00, "R8");
    for (int j = 0; j < NCFG; j++) rd8(8'h51 + 8'(j), CFG_DFLT, "R8");
    rd8(8'h37, 8'h00, "R9");
    rd8(8'h20, 8'h00, "R9");

    // R5: writes dropped while locked
    wr8(8'h51, 8'hA5);
    wr8(8'h02, 8'h11);
    rd8(8'h51, CFG_DFLT, "R5");
    rd8(8'h02, MAC_DFLT[23:16], "R5");

    // R4: one mode bit is not enough
    wr8(8'h50, 8'h80);
    rd8(8'h50, 8'h80, "R4");
    wr8(8'h52, 8'h3C);
    rd8(8'h52, CFG_DFLT, "R4");

    // R4: unlock, readback masks low bits, protected writes land
    wr8(8'h50, 8'hC5);
    rd8(8'h50, 8'hC0, "R4");
    wr8(8'h51, 8'h01);
    wr8(8'h52, 8'h02);
    wr8(8'h53, 8'h03);
    wr8(8'h05, 8'hEE);
    rd8(8'h51, 8'h01, "R4");
    rd8(8'h52, 8'h02, "R4");
    rd8(8'h53, 8'h03, "R4");
    rd8(8'h05, 8'hEE, "R4");
    rd8(8'h54, 8'h00, "R9");

    // R9: command write without bit 4 does nothing
    wr8(8'h37, 8'hEF);
    rd8(8'h37, 8'h00, "R9");
    rd8(8'h51, 8'h01, "R9");

    // R6: relock
    wr8(8'h50, 8'h40);
    wr8(8'h51, 8'h99);
    rd8(8'h51, 8'h01, "R6");
    rd8(8'h50, 8'h40, "R6");

    // R2 / R3 / R7: soft reset from an unlocked state
    wr8(8'h50, 8'hC0);
    wr8(8'h52, 8'h77);
    wr8(8'h37, 8'h10);
    wr8(8'h50, 8'hC0);
    rd8(8'h00, 8'h10, "R7");
    for (int k = 3; k <= RST_CYC + 1; k++)
      rd8(8'h37, (k <= RST_CYC) ? 8'h10 : 8'h00, "R3");
    rd8(8'h50, 8'h00, "R8");
    rd8(8'h52, CFG_DFLT, "R2");
    rd8(8'h51, CFG_DFLT, "R2");
    rd8(8'h05, MAC_DFLT[47:40], "R2");
    wr8(8'h53, 8'h44);
    rd8(8'h53, CFG_DFLT, "R7");

    // R7: repeated reset and writes during busy are ignored
    wr8(8'h37, 8'h10);
    wr8(8'h37, 8'h10);
    for (int k = 2; k <= RST_CYC + 1; k++)
      rd8(8'h37, (k <= RST_CYC) ? 8'h10 : 8'h00, "R7");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: %0d reads never returned, expected 0", exp_q.size());
    end
    done = 1'b1;
    summary();
  end

endmodule